// File: doc/BRIEF.md
# Shadow Mask Pixel Overlay

This stage sits in a video output pipeline. It scales each RGB pixel by gains taken from a small tile pattern that repeats across the screen, which gives the look of a CRT phosphor mask. A host port fills a 16x16 pattern store. On the pixel side, a horizontal phase counter and a vertical phase counter pick one store entry for each active pixel. The counters have programmable periods, so the tile can be any size from 1x1 to 16x16.

Each store entry holds a three-bit channel select and two 4-bit gain codes. For each channel, the select bit picks one of the two codes:
- Set: the high code, used as a boosting gain above unity.
- Clear: the low code, used as a dimming gain below unity.

A global 4-bit strength value pulls both codes toward neutral before they are used. Each channel is then multiplied, scaled and clamped.

The host clock and the pixel clock meet only at the two-port pattern store. The host side writes the store. The pixel side reads it through a register.

Top module: `shmask_overlay`

## Requirements
- R1: The pattern store holds 256 entries of 11 bits. For each active pixel, the entry is read at index {y_phase[3:0], x_phase[3:0]}, with the vertical phase in the high nibble.
- R2: A host write lands in the store only when the word address is in the window 0x100 to 0x1FF. The store index is host_addr_i[7:0] and the entry is host_wdata_i[10:0]. A write outside the window leaves every entry unchanged.
- R3: Each entry is decoded as follows:
  - Bit 10 is the red select, bit 9 the green select and bit 8 the blue select.
  - A channel whose select bit is set uses gain 16 + hi, where hi is bits [7:4].
  - A channel whose select bit is clear uses gain lo, where lo is bits [3:0].
- R4: The horizontal phase counter behaves as follows:
  - It returns to 0 on a line start or a frame start.
  - It advances once per active pixel.
  - When it equals ctrl_period_x_i, it wraps to 0 instead of advancing.
- R5: The vertical phase counter behaves as follows:
  - It returns to 0 on a frame start.
  - It advances on each line start except the first line start after a frame start.
  - When it equals ctrl_period_y_i, it wraps to 0 instead of advancing.
- R6: Each channel result is (pixel * gain) >> 4, computed to 9 bits, so a gain of 16 returns the pixel unchanged.
- R7: When the 9-bit channel result reaches 256 or more, the output is 0xFF.
- R8: The strength value s changes the two codes before they are decoded:
  - s = 15 leaves the entry unchanged.
  - Otherwise hi becomes ((s+1)*hi)/16 and lo becomes 15 - ((s+1)*(15-lo))/16.
  - The select bits are never changed.
- R9: Timing and bypass:
  - The output valid and the pixel data follow the input by exactly 3 pixel-clock cycles.
  - With ctrl_enable_i low when the pixel is taken in, the pixel leaves unchanged with the same latency.
- R10: While reset is asserted, pix_valid_o and all colour outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| host_clk_i | input | 1 | Host write clock |
| pix_clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| host_we_i | input | 1 | Host write strobe |
| host_addr_i | input | 10 | Host word address |
| host_wdata_i | input | 32 | Host write data |
| ctrl_enable_i | input | 1 | Mask enable |
| ctrl_period_x_i | input | 4 | Last horizontal phase before wrap |
| ctrl_period_y_i | input | 4 | Last vertical phase before wrap |
| ctrl_strength_i | input | 4 | Global pattern strength |
| frame_start_i | input | 1 | Frame start pulse (blanking cycle) |
| line_start_i | input | 1 | Line start pulse (blanking cycle) |
| pix_valid_i | input | 1 | Active pixel strobe |
| pix_r_i | input | 8 | Red in |
| pix_g_i | input | 8 | Green in |
| pix_b_i | input | 8 | Blue in |
| pix_valid_o | output | 1 | Active pixel strobe, delayed |
| pix_r_o | output | 8 | Red out |
| pix_g_o | output | 8 | Green out |
| pix_b_o | output | 8 | Blue out |

## Verification
The bench builds the block with its default parameters: 4-bit phases, 8-bit pixels, a 10-bit host address and a window base of 0x100.

With these defaults, periods of 15 in both directions walk all 256 store indices, so R1 and the out-of-window writes of R2 can be checked entry by entry. An 8-bit pixel of 255 under a gain of 31 reaches 494, which drives the clamp in R7. Strength values of 0, 3, 7 and 15 cover both the neutral end and the identity end of R8.

// File: rtl/shm_pkg.sv
package shm_pkg;
  localparam int unsigned CODE_W   = 4;
  localparam int unsigned NUM_CH   = 3;
  localparam int unsigned ENTRY_W  = NUM_CH + 2 * CODE_W;
  localparam int unsigned GAIN_W   = CODE_W + 1;

  typedef logic [ENTRY_W-1:0] entry_t;
  typedef logic [GAIN_W-1:0]  gain_t;

  // ((s+1)*c) >> CODE_W
  function automatic logic [CODE_W-1:0] scale_code(input logic [CODE_W-1:0] c,
                                                   input logic [CODE_W-1:0] s);
    logic [CODE_W:0]     k;
    logic [2*CODE_W+1:0] p;
    k = {1'b0, s} + 1'b1;
    p = {{(CODE_W+1){1'b0}}, k} * {{(CODE_W+2){1'b0}}, c};
    return p[2*CODE_W-1:CODE_W];
  endfunction
endpackage

// File: rtl/shm_pattern_ram.sv
module shm_pattern_ram
  import shm_pkg::*;
#(
  parameter int unsigned IDX_W    = 8,
  parameter int unsigned ADDR_W   = 10,
  parameter int unsigned HOST_DW  = 32,
  parameter int unsigned WIN_BASE = 'h100
) (
  input  logic               wr_clk_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [HOST_DW-1:0] wdata_i,
  input  logic               rd_clk_i,
  input  logic               rst_ni,
  input  logic [IDX_W-1:0]   rd_idx_i,
  output entry_t             rd_data_o
);
  localparam int unsigned DEPTH = 1 << IDX_W;
  localparam logic [ADDR_W:0] WIN_LO = (ADDR_W+1)'(WIN_BASE);
  localparam logic [ADDR_W:0] WIN_HI = (ADDR_W+1)'(WIN_BASE + DEPTH);

  entry_t mem [DEPTH];
  logic   win_hit;
  logic   unused_wdata;

  assign unused_wdata = ^wdata_i[HOST_DW-1:ENTRY_W];
  assign win_hit = we_i && ({1'b0, addr_i} >= WIN_LO) && ({1'b0, addr_i} < WIN_HI);

  always_ff @(posedge wr_clk_i) begin
    if (win_hit) mem[addr_i[IDX_W-1:0]] <= wdata_i[ENTRY_W-1:0];
  end

  always_ff @(posedge rd_clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_data_o <= '0;
    else         rd_data_o <= mem[rd_idx_i];
  end
endmodule

// File: rtl/shm_phase_gen.sv
module shm_phase_gen #(
  parameter int unsigned PHASE_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               frame_start_i,
  input  logic               line_start_i,
  input  logic               pix_valid_i,
  input  logic [PHASE_W-1:0] period_x_i,
  input  logic [PHASE_W-1:0] period_y_i,
  output logic [PHASE_W-1:0] x_o,
  output logic [PHASE_W-1:0] y_o
);
  logic first_line_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_o          <= '0;
      y_o          <= '0;
      first_line_q <= 1'b1;
    end else if (frame_start_i) begin
      x_o          <= '0;
      y_o          <= '0;
      first_line_q <= 1'b1;
    end else if (line_start_i) begin
      x_o <= '0;
      if (first_line_q) first_line_q <= 1'b0;
      else              y_o <= (y_o == period_y_i) ? '0 : y_o + 1'b1;
    end else if (pix_valid_i) begin
      x_o <= (x_o == period_x_i) ? '0 : x_o + 1'b1;
    end
  end

  a_r4_x_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_valid_i && !line_start_i && !frame_start_i && x_o == period_x_i) |=> (x_o == '0));
  a_r4_line_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_start_i |=> (x_o == '0));
  a_r5_frame_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i |=> (y_o == '0));
endmodule

// File: rtl/shm_gain_decode.sv
module shm_gain_decode
  import shm_pkg::*;
(
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  entry_t                        entry_i,
  input  logic [CODE_W-1:0]             strength_i,
  output logic [NUM_CH-1:0][GAIN_W-1:0] gain_o
);
  logic [CODE_W-1:0] hi_soft, lo_soft;

  assign hi_soft = scale_code(entry_i[2*CODE_W-1:CODE_W], strength_i);
  // 15 - ((s+1)*(15-lo))/16, using ~x == 15-x
  assign lo_soft = ~scale_code(~entry_i[CODE_W-1:0], strength_i);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) gain_o[ch] <= '0;
      else         gain_o[ch] <= entry_i[2*CODE_W+ch] ? {1'b1, hi_soft} : {1'b0, lo_soft};
    end
  end

  // R3: red select bit picks a gain of at least 16
  a_r3_red_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entry_i[ENTRY_W-1] |=> gain_o[NUM_CH-1][GAIN_W-1]);
  a_r8_full_strength: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strength_i == '1 && !entry_i[ENTRY_W-1]) |=> (gain_o[NUM_CH-1] == {1'b0, $past(entry_i[CODE_W-1:0])}));
endmodule

// File: rtl/shm_chan_scale.sv
module shm_chan_scale
  import shm_pkg::*;
#(
  parameter int unsigned PIX_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [PIX_W-1:0] pix_i,
  input  gain_t            gain_i,
  output logic [PIX_W-1:0] pix_o
);
  localparam int unsigned PROD_W = PIX_W + GAIN_W;
  localparam int unsigned SCL_W  = PROD_W - CODE_W;

  logic [PROD_W-1:0] prod;
  logic [SCL_W-1:0]  scaled;
  logic [PIX_W-1:0]  res;

  assign prod   = {{GAIN_W{1'b0}}, pix_i} * {{PIX_W{1'b0}}, gain_i};
  assign scaled = prod[PROD_W-1:CODE_W];
  assign res    = (|scaled[SCL_W-1:PIX_W]) ? '1 : scaled[PIX_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pix_o <= '0;
    else         pix_o <= en_i ? res : pix_i;
  end

  a_r6_unity: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && gain_i == GAIN_W'(1 << CODE_W)) |=> (pix_o == $past(pix_i)));
  a_r7_clamp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && pix_i == '1 && gain_i > GAIN_W'(1 << CODE_W)) |=> (pix_o == '1));
  a_r9_bypass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (pix_o == $past(pix_i)));
endmodule

// File: rtl/shmask_overlay.sv
module shmask_overlay
  import shm_pkg::*;
#(
  parameter int unsigned PHASE_W  = 4,
  parameter int unsigned PIX_W    = 8,
  parameter int unsigned ADDR_W   = 10,
  parameter int unsigned HOST_DW  = 32,
  parameter int unsigned WIN_BASE = 'h100
) (
  input  logic               host_clk_i,
  input  logic               pix_clk_i,
  input  logic               rst_ni,
  input  logic               host_we_i,
  input  logic [ADDR_W-1:0]  host_addr_i,
  input  logic [HOST_DW-1:0] host_wdata_i,
  input  logic               ctrl_enable_i,
  input  logic [PHASE_W-1:0] ctrl_period_x_i,
  input  logic [PHASE_W-1:0] ctrl_period_y_i,
  input  logic [CODE_W-1:0]  ctrl_strength_i,
  input  logic               frame_start_i,
  input  logic               line_start_i,
  input  logic               pix_valid_i,
  input  logic [PIX_W-1:0]   pix_r_i,
  input  logic [PIX_W-1:0]   pix_g_i,
  input  logic [PIX_W-1:0]   pix_b_i,
  output logic               pix_valid_o,
  output logic [PIX_W-1:0]   pix_r_o,
  output logic [PIX_W-1:0]   pix_g_o,
  output logic [PIX_W-1:0]   pix_b_o
);
  localparam int unsigned IDX_W = 2 * PHASE_W;

  logic [PHASE_W-1:0] x_ph, y_ph;
  entry_t             entry_q;
  logic [NUM_CH-1:0][GAIN_W-1:0] gain_q;
  logic [NUM_CH-1:0][PIX_W-1:0]  pix_in, pix_s1, pix_s2, pix_out;
  logic vld_s1, vld_s2, en_s1, en_s2;
  logic [1:0] since_rst;

  // channel 2 = red, 1 = green, 0 = blue (matches entry select bits)
  assign pix_in  = {pix_r_i, pix_g_i, pix_b_i};
  assign pix_r_o = pix_out[2];
  assign pix_g_o = pix_out[1];
  assign pix_b_o = pix_out[0];

  shm_phase_gen #(.PHASE_W(PHASE_W)) u_phase (
    .clk_i         (pix_clk_i),
    .rst_ni        (rst_ni),
    .frame_start_i (frame_start_i),
    .line_start_i  (line_start_i),
    .pix_valid_i   (pix_valid_i),
    .period_x_i    (ctrl_period_x_i),
    .period_y_i    (ctrl_period_y_i),
    .x_o           (x_ph),
    .y_o           (y_ph)
  );

  shm_pattern_ram #(
    .IDX_W(IDX_W), .ADDR_W(ADDR_W), .HOST_DW(HOST_DW), .WIN_BASE(WIN_BASE)
  ) u_ram (
    .wr_clk_i  (host_clk_i),
    .we_i      (host_we_i),
    .addr_i    (host_addr_i),
    .wdata_i   (host_wdata_i),
    .rd_clk_i  (pix_clk_i),
    .rst_ni    (rst_ni),
    .rd_idx_i  ({y_ph, x_ph}),
    .rd_data_o (entry_q)
  );

  shm_gain_decode u_dec (
    .clk_i      (pix_clk_i),
    .rst_ni     (rst_ni),
    .entry_i    (entry_q),
    .strength_i (ctrl_strength_i),
    .gain_o     (gain_q)
  );

  always_ff @(posedge pix_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_s1 <= '0; pix_s2 <= '0;
      vld_s1 <= 1'b0; vld_s2 <= 1'b0; pix_valid_o <= 1'b0;
      en_s1  <= 1'b0; en_s2  <= 1'b0;
      since_rst <= '0;
    end else begin
      pix_s1 <= pix_in;      pix_s2 <= pix_s1;
      vld_s1 <= pix_valid_i; vld_s2 <= vld_s1; pix_valid_o <= vld_s2;
      en_s1  <= ctrl_enable_i; en_s2 <= en_s1;
      if (since_rst != 2'd3) since_rst <= since_rst + 1'b1;
    end
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_scale
    shm_chan_scale #(.PIX_W(PIX_W)) u_scale (
      .clk_i  (pix_clk_i),
      .rst_ni (rst_ni),
      .en_i   (en_s2),
      .pix_i  (pix_s2[ch]),
      .gain_i (gain_q[ch]),
      .pix_o  (pix_out[ch])
    );
  end

  a_r9_latency: assert property (@(posedge pix_clk_i) disable iff (!rst_ni)
    (since_rst == 2'd3) |-> (pix_valid_o == $past(pix_valid_i, 3)));
  a_r10_reset_out: assert property (@(posedge pix_clk_i)
    !rst_ni |-> (!pix_valid_o && pix_out == '0));
endmodule

// File: tb/shmask_overlay_tb_top.sv
module shmask_overlay_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_ni = 1'b0;
  logic host_we = 1'b0;
  logic [9:0] host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic en = 1'b0;
  logic [3:0] px = '0, py = '0, str = 4'd15;
  logic fs = 1'b0, ls = 1'b0, vl = 1'b0;
  logic [7:0] ri = '0, gi = '0, bi = '0;
  logic vo;
  logic [7:0] ro, go, bo;

  shmask_overlay dut_i (
    .host_clk_i(clk), .pix_clk_i(clk), .rst_ni(rst_ni),
    .host_we_i(host_we), .host_addr_i(host_addr), .host_wdata_i(host_wdata),
    .ctrl_enable_i(en), .ctrl_period_x_i(px), .ctrl_period_y_i(py),
    .ctrl_strength_i(str), .frame_start_i(fs), .line_start_i(ls),
    .pix_valid_i(vl), .pix_r_i(ri), .pix_g_i(gi), .pix_b_i(bi),
    .pix_valid_o(vo), .pix_r_o(ro), .pix_g_o(go), .pix_b_o(bo)
  );

  int tests = 0, fails = 0, k = 0;
  logic [10:0] mm [256];
  int mx = 0, my = 0;
  bit mfirst = 1'b1;
  bit hv [4];
  logic [7:0] hr [4], hg [4], hb [4];
  string ht [4];

  function automatic logic [7:0] exp_ch(input logic [7:0] p, input logic [10:0] e,
                                        input int ch, input logic [3:0] s, input bit ena);
    int hi, lo, g, v;
    hi = e[7:4]; lo = e[3:0];
    if (s != 4'd15) begin
      hi = ((s + 1) * hi) / 16;
      lo = 15 - ((s + 1) * (15 - lo)) / 16;
    end
    g = e[8+ch] ? 16 + hi : lo;
    v = (p * g) / 16;
    if (!ena) return p;
    return (v > 255) ? 8'hFF : v[7:0];
  endfunction

  task automatic tick();
    int c;
    @(negedge clk);
    c = (k + 1) % 4;
    tests++;
    if (vo !== hv[c] || (hv[c] && (ro !== hr[c] || go !== hg[c] || bo !== hb[c]))) begin
      fails++;
      $display("FAIL %s: valid=%b rgb=%h%h%h expected valid=%b rgb=%h%h%h",
               ht[c], vo, ro, go, bo, hv[c], hr[c], hg[c], hb[c]);
    end
  endtask

  task automatic drive(input bit f, input bit l, input bit v,
                       input logic [7:0] r, input logic [7:0] g, input logic [7:0] b,
                       input string tag);
    logic [10:0] e;
    tick();
    host_we = 1'b0; fs = f; ls = l; vl = v; ri = r; gi = g; bi = b;
    e = mm[my * 16 + mx];
    hv[k%4] = v; ht[k%4] = tag;
    hr[k%4] = exp_ch(r, e, 2, str, en);
    hg[k%4] = exp_ch(g, e, 1, str, en);
    hb[k%4] = exp_ch(b, e, 0, str, en);
    if (f) begin mx = 0; my = 0; mfirst = 1'b1; end
    else if (l) begin
      mx = 0;
      if (mfirst) mfirst = 1'b0;
      else my = (my == py) ? 0 : (my + 1) % 16;
    end else if (v) mx = (mx == px) ? 0 : (mx + 1) % 16;
    k++;
  endtask

  task automatic hwrite(input logic [9:0] a, input logic [31:0] d);
    tick();
    fs = 0; ls = 0; vl = 0;
    host_we = 1'b1; host_addr = a; host_wdata = d;
    hv[k%4] = 1'b0; ht[k%4] = "R2 host write";
    if (a >= 10'h100 && a < 10'h200) mm[a[7:0]] = d[10:0];
    k++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 8'h0, 8'h0, 8'h0, "R9 idle");
  endtask

  task automatic frame(input int lines, input int npix, input bit gaps, input string tag);
    drive(1, 0, 0, 8'h0, 8'h0, 8'h0, tag);
    for (int l = 0; l < lines; l++) begin
      drive(0, 1, 0, 8'h0, 8'h0, 8'h0, tag);
      for (int p = 0; p < npix; p++) begin
        if (gaps && ($urandom % 4 == 0)) idle(1);
        drive(0, 0, 1, 8'($urandom), 8'($urandom), 8'($urandom), tag);
      end
      idle(2);
    end
    idle(4);
  endtask

  task automatic fill_random();
    for (int i = 0; i < 256; i++) hwrite(10'h100 + 10'(i), $urandom);
    idle(2);
  endtask

  initial begin
    void'($urandom(32'd7131));
    for (int i = 0; i < 4; i++) begin hv[i] = 0; hr[i] = 0; hg[i] = 0; hb[i] = 0; ht[i] = "R10"; end
    repeat (3) @(negedge clk);
    tests++;
    if (vo !== 1'b0 || ro !== 8'h0 || go !== 8'h0 || bo !== 8'h0) begin
      fails++;
      $display("FAIL R10 reset: valid=%b rgb=%h%h%h expected 0 000000", vo, ro, go, bo);
    end
    rst_ni = 1'b1;

    fill_random();
    en = 1; str = 15; px = 3; py = 1;
    frame(5, 10, 1'b0, "R1 R3 R4 R5 R6 tile 4x2");
    px = 15; py = 15;
    frame(18, 34, 1'b1, "R1 R4 R5 full 16x16 with gaps");
    px = 5; py = 3;
    str = 0; frame(9, 13, 1'b0, "R8 strength 0");
    str = 7; frame(9, 13, 1'b1, "R8 strength 7");
    str = 3; frame(9, 13, 1'b0, "R8 strength 3");
    str = 15;
    px = 9; py = 12;
    frame(3, 5, 1'b0, "R4 R5 short lines");

    px = 0; py = 0;
    hwrite(10'h100, 32'hFFFF_F7FF); idle(2);
    drive(1, 0, 0, 0, 0, 0, "R7"); drive(0, 1, 0, 0, 0, 0, "R7");
    drive(0, 0, 1, 8'hFF, 8'h80, 8'h10, "R7 clamp gain 31");
    drive(0, 0, 1, 8'h84, 8'h85, 8'h01, "R7 clamp near edge");
    idle(4);
    hwrite(10'h100, 32'h0000_0700); idle(2);
    drive(1, 0, 0, 0, 0, 0, "R6"); drive(0, 1, 0, 0, 0, 0, "R6");
    drive(0, 0, 1, 8'hA5, 8'h3C, 8'hFF, "R6 unity gain 16");
    drive(0, 0, 1, 8'h00, 8'h01, 8'h7F, "R6 unity gain 16");
    idle(4);
    hwrite(10'h100, 32'h0000_0420); idle(2);
    drive(1, 0, 0, 0, 0, 0, "R3"); drive(0, 1, 0, 0, 0, 0, "R3");
    drive(0, 0, 1, 8'hC8, 8'hC8, 8'hC8, "R3 red hi=2, green/blue lo=0");
    idle(4);

    en = 0; px = 3; py = 3;
    frame(4, 8, 1'b1, "R9 disabled passthrough");
    en = 1;

    fill_random();
    for (int i = 0; i < 40; i++) hwrite(10'($urandom % 256), $urandom);
    for (int i = 0; i < 40; i++) hwrite(10'h200 + 10'($urandom % 512), $urandom);
    hwrite(10'h0FF, 32'h0); hwrite(10'h200, 32'h7FF); hwrite(10'h3FF, 32'h0);
    idle(2);
    px = 15; py = 15;
    frame(16, 16, 1'b0, "R2 out-of-window writes ignored");

    idle(6);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule